// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A line-setup byte selects the number of data bits, one or two stop bits, whether a parity bit is sent and how it is formed, and a break override. Bit timing comes from a 16-bit divisor. The divisor is applied to a reference tick enable, and each bit lasts sixteen divided periods.

A character enters through a one-deep holding register with a valid/ready handshake. When the shifter is free, the held character moves into it together with a snapshot of the line setup and the divisor. Consecutive characters therefore go out with no idle time between them. Two flags report separately whether the holding register and the shifter are empty.

Top module: `async_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and break is off, `txLine` is 1, and `holdEmpty`, `shiftEmpty` and `inReady` are 1.
- R2: A frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop bit(s) at 1.
- R3: `lineCtrl[1:0]` selects the word length: 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only the low bits of `inData` are sent.
- R4: `lineCtrl[2]` = 0 sends one stop bit and `lineCtrl[2]` = 1 sends two.
- R5: With `lineCtrl[3]` = 1 a parity bit follows the data. With `lineCtrl[4]` = 1 the ones in data plus parity total an even count, and with `lineCtrl[4]` = 0 an odd count.
- R6: With `lineCtrl[3]` = 1 and `lineCtrl[5]` = 1 the parity bit is a constant: 0 when `lineCtrl[4]` = 1 and 1 when `lineCtrl[4]` = 0. With `lineCtrl[3]` = 0, `lineCtrl[5]` adds no bit.
- R7: While `lineCtrl[6]` = 1, `txLine` is 0 continuously, whether idle or mid-frame. Once the bit clears, the line returns to its normal value.
- R8: Every bit lasts exactly 16 × `divisor` asserted `refTick` cycles. A divisor of 0 counts as 65536. The line changes only on a cycle that follows an asserted `refTick`, or when a frame starts from idle.
- R9: A byte is taken on a cycle with `inValid` and `inReady` both high. `inReady` is low while the holding register is full. A byte held when a frame's last stop bit ends starts the next frame with no idle gap.
- R10: `holdEmpty` goes low after a byte is accepted and stays low until the byte moves to the shifter. `shiftEmpty` is low from the start bit through the end of the last stop bit, and returns high only when no byte is waiting.
- R11: Bits 0 to 5 of `lineCtrl` and `divisor` are sampled when a frame starts. Changes made during a frame apply from the next start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | Reference tick enable that drives the bit timer |
| divisor | input | DIV_W | Bit-rate divisor, 0 means 65536 |
| lineCtrl | input | 7 | Line setup: word length, stop count, parity enable, even select, constant parity, break |
| inData | input | DATA_W | Character to send |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Holding register can take a character |
| txLine | output | 1 | Serial output, idle high |
| holdEmpty | output | 1 | Holding register empty |
| shiftEmpty | output | 1 | No frame in progress |

## Verification
The bench builds the block with its defaults: 8-bit data, 16-bit divisor and sixteen sub-periods per bit. Divisors 1 to 3 keep each bit at 16 to 48 reference ticks, so random frames with every line setup fit in the run. The bench also thins `refTick` at random, which tests whether the bit timer counts only enabled ticks. A divisor of 0 is checked separately: the start bit must still be low long after any small divisor would have ended it, which exercises the 16-bit wrap.

// File: rtl/atx_pkg.sv
package atx_pkg;

  // Line setup byte; packed MSB first so bit 6 is break, bits 1:0 word length.
  typedef struct packed {
    logic       brk;
    logic       sticky;
    logic       evenPar;
    logic       parEn;
    logic       twoStop;
    logic [1:0] wordSel;
  } lineCfg_t;

  localparam int CFG_W = $bits(lineCfg_t);

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic take;      // move holding register into shifter, start bit
    logic sendData;  // next data bit on the line
    logic sendPar;   // parity bit on the line
    logic sendStop;  // stop level on the line
  } dpStrobe_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_t;

endpackage

// File: rtl/atx_baud.sv
module atx_baud #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             bitEnd
);
  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [SUB_W-1:0] subCnt;
  logic [DIV_W-1:0] divLast;
  logic             divHit;

  // Divisor 0 wraps to all ones, giving a full 2**DIV_W period.
  assign divLast = divisor - DIV_W'(1);
  assign divHit  = (divCnt == divLast);
  assign bitEnd  = refTick && divHit && (subCnt == SUB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      subCnt <= '0;
    end else if (restart) begin
      divCnt <= '0;
      subCnt <= '0;
    end else if (refTick) begin
      if (divHit) begin
        divCnt <= '0;
        subCnt <= (subCnt == SUB_LAST) ? '0 : subCnt + SUB_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

endmodule

// File: rtl/atx_ctrl.sv
module atx_ctrl
  import atx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdFull,
  input  logic       bitEnd,
  input  logic [1:0] frameWordSel,
  input  logic       frameParEn,
  input  logic       frameTwoStop,
  output dpStrobe_t  strobe,
  output logic       restart,
  output logic       shiftEmpty
);
  localparam int CNT_W = $clog2(DATA_W);

  phase_t           state, nxtState;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             stopCnt;

  // Shortest word is DATA_W-3 bits, so its last index is DATA_W-4.
  assign lastIdx    = CNT_W'(DATA_W - 4) + CNT_W'(frameWordSel);
  assign shiftEmpty = (state == PH_IDLE);

  always_comb begin
    strobe   = '0;
    restart  = 1'b0;
    nxtState = state;
    case (state)
      PH_IDLE: begin
        if (holdFull) begin
          strobe.take = 1'b1;
          restart     = 1'b1;
          nxtState    = PH_START;
        end
      end
      PH_START: begin
        if (bitEnd) begin
          strobe.sendData = 1'b1;
          nxtState        = PH_DATA;
        end
      end
      PH_DATA: begin
        if (bitEnd) begin
          if (bitCnt != lastIdx) begin
            strobe.sendData = 1'b1;
          end else if (frameParEn) begin
            strobe.sendPar = 1'b1;
            nxtState       = PH_PARITY;
          end else begin
            strobe.sendStop = 1'b1;
            nxtState        = PH_STOP;
          end
        end
      end
      PH_PARITY: begin
        if (bitEnd) begin
          strobe.sendStop = 1'b1;
          nxtState        = PH_STOP;
        end
      end
      PH_STOP: begin
        if (bitEnd && !(frameTwoStop && !stopCnt)) begin
          if (holdFull) begin
            strobe.take = 1'b1;
            restart     = 1'b1;
            nxtState    = PH_START;
          end else begin
            nxtState = PH_IDLE;
          end
        end
      end
      default: nxtState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      bitCnt  <= '0;
      stopCnt <= 1'b0;
    end else begin
      state   <= nxtState;
      bitCnt  <= (state == PH_DATA) ? bitCnt + CNT_W'(bitEnd) : '0;
      stopCnt <= (state == PH_STOP) ? (stopCnt | bitEnd) : 1'b0;
    end
  end

endmodule

// File: rtl/atx_datapath.sv
module atx_datapath
  import atx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  lineCfg_t          liveCfg,
  input  logic [DIV_W-1:0]  divisorIn,
  input  dpStrobe_t         strobe,
  output logic              inReady,
  output logic              holdFull,
  output logic [1:0]        frameWordSel,
  output logic              frameParEn,
  output logic              frameTwoStop,
  output logic [DIV_W-1:0]  frameDiv,
  output logic              txLine
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] wordMask;
  logic              parBit;
  logic              parNext;
  logic              rawPar;
  logic              lineReg;
  logic              accept;

  assign inReady = !holdFull;
  assign accept  = inValid && !holdFull;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      wordMask[i] = (i < (DATA_W - 3 + int'(liveCfg.wordSel)));
    end
    rawPar = ^(holdReg & wordMask);
    if (liveCfg.sticky) parNext = !liveCfg.evenPar;
    else                parNext = liveCfg.evenPar ? rawPar : !rawPar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (accept) begin
      holdReg  <= inData;
      holdFull <= 1'b1;
    end else if (strobe.take) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg     <= '0;
      parBit       <= 1'b0;
      lineReg      <= 1'b1;
      frameWordSel <= '0;
      frameParEn   <= 1'b0;
      frameTwoStop <= 1'b0;
      frameDiv     <= DIV_W'(1);
    end else if (strobe.take) begin
      shiftReg     <= holdReg;
      parBit       <= parNext;
      lineReg      <= 1'b0;
      frameWordSel <= liveCfg.wordSel;
      frameParEn   <= liveCfg.parEn;
      frameTwoStop <= liveCfg.twoStop;
      frameDiv     <= divisorIn;
    end else if (strobe.sendData) begin
      lineReg  <= shiftReg[0];
      shiftReg <= shiftReg >> 1;
    end else if (strobe.sendPar) begin
      lineReg <= parBit;
    end else if (strobe.sendStop) begin
      lineReg <= 1'b1;
    end
  end

  // Break overrides the registered line level immediately.
  assign txLine = lineReg && !liveCfg.brk;

endmodule

// File: rtl/async_tx.sv
module async_tx
  import atx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [CFG_W-1:0]  lineCtrl,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              shiftEmpty
);
  lineCfg_t         liveCfg;
  dpStrobe_t        strobe;
  logic             holdFull;
  logic             restart;
  logic             bitEnd;
  logic [1:0]       frameWordSel;
  logic             frameParEn;
  logic             frameTwoStop;
  logic [DIV_W-1:0] frameDiv;

  assign liveCfg   = lineCfg_t'(lineCtrl);
  assign holdEmpty = !holdFull;

  atx_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .inData       (inData),
    .inValid      (inValid),
    .liveCfg      (liveCfg),
    .divisorIn    (divisor),
    .strobe       (strobe),
    .inReady      (inReady),
    .holdFull     (holdFull),
    .frameWordSel (frameWordSel),
    .frameParEn   (frameParEn),
    .frameTwoStop (frameTwoStop),
    .frameDiv     (frameDiv),
    .txLine       (txLine)
  );

  atx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .holdFull     (holdFull),
    .bitEnd       (bitEnd),
    .frameWordSel (frameWordSel),
    .frameParEn   (frameParEn),
    .frameTwoStop (frameTwoStop),
    .strobe       (strobe),
    .restart      (restart),
    .shiftEmpty   (shiftEmpty)
  );

  atx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .restart (restart),
    .divisor (frameDiv),
    .bitEnd  (bitEnd)
  );

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk #(
  parameter int CFG_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             refTick,
  input logic [CFG_W-1:0] lineCtrl,
  input logic             inValid,
  input logic             inReady,
  input logic             txLine,
  input logic             holdEmpty,
  input logic             shiftEmpty
);
  logic brk;
  assign brk = lineCtrl[CFG_W-1];

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEmpty && !brk) |-> txLine);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(shiftEmpty) && !brk) |-> !txLine);

  a_r7_break_low: assert property (@(posedge clk) disable iff (!rstN)
    brk |-> !txLine);

  a_r8_tick_paced: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(refTick) && $stable(brk) && !$fell(shiftEmpty)) |-> $stable(txLine));

  a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !holdEmpty);

  a_r10_idle_drained: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftEmpty) |-> $past(holdEmpty));

endmodule

bind async_tx async_tx_chk #(.CFG_W(atx_pkg::CFG_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refTick    (refTick),
  .lineCtrl   (lineCtrl),
  .inValid    (inValid),
  .inReady    (inReady),
  .txLine     (txLine),
  .holdEmpty  (holdEmpty),
  .shiftEmpty (shiftEmpty)
);

// File: tb/tb_async_tx.sv
`timescale 1ns/1ps
module tb_async_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [6:0]  lineCtrl = 7'd0;
  logic [7:0]  inData = 8'd0;
  logic        inValid = 1'b0;
  logic        inReady, txLine, holdEmpty, shiftEmpty;

  async_tx dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .divisor(divisor),
    .lineCtrl(lineCtrl), .inData(inData), .inValid(inValid),
    .inReady(inReady), .txLine(txLine), .holdEmpty(holdEmpty),
    .shiftEmpty(shiftEmpty)
  );

  always #2 clk = ~clk;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  // Expected frames, pushed at acceptance.
  logic [7:0]  qData[256];
  logic [6:0]  qCfg[256];
  logic [15:0] qDiv[256];
  string       qTag[256];
  int          qHead = 0;
  int          qTail = 0;

  // Line monitor state.
  bit          monEn = 1'b1;
  bit          inFrame = 1'b0;
  int          cnt, bitLen, nBits;
  logic [11:0] gotV, expV, mask;
  string       curTag;
  bit          gapLog[256];
  int          framesStarted = 0;
  int          refMode = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [6:0] mkCfg(input bit brk, input bit sticky, input bit even,
                                       input bit par, input bit two, input logic [1:0] ws);
    return {brk, sticky, even, par, two, ws};
  endfunction

  function automatic int frameOf(input logic [7:0] d, input logic [6:0] c, output logic [11:0] v);
    int n, idx;
    logic x;
    v = '0;
    x = 1'b0;
    n = 5 + int'(c[1:0]);
    for (int i = 0; i < n; i++) begin
      v[1+i] = d[i];
      x ^= d[i];
    end
    idx = 1 + n;
    if (c[3]) begin
      v[idx] = c[5] ? ~c[4] : (c[4] ? x : ~x);
      idx++;
    end
    v[idx] = 1'b1;
    idx++;
    if (c[2]) begin
      v[idx] = 1'b1;
      idx++;
    end
    return idx;
  endfunction

  task automatic startFrame(input bit gap);
    if (qHead == qTail) begin
      check(1'b0, "R2 start bit with nothing queued", 32'd0, 32'd1);
      monEn = 1'b0;
    end else begin
      nBits  = frameOf(qData[qHead % 256], qCfg[qHead % 256], expV);
      bitLen = 16 * ((qDiv[qHead % 256] == 16'd0) ? 65536 : int'(qDiv[qHead % 256]));
      curTag = qTag[qHead % 256];
      qHead++;
      cnt = 0;
      gotV = '0;
      inFrame = 1'b1;
      gapLog[framesStarted % 256] = gap;
      framesStarted++;
    end
  endtask

  // Monitor: counts ticks sampled at the last posedge, samples mid-bit.
  always @(negedge clk) begin
    if (!rstN) begin
      inFrame = 1'b0;
    end else if (monEn) begin
      if (inFrame) begin
        if (refTick) begin
          cnt++;
          if ((cnt % bitLen) == bitLen / 2 && (cnt / bitLen) < nBits)
            gotV[cnt / bitLen] = txLine;
          if (cnt == nBits * bitLen) begin
            mask = (12'h1 << nBits) - 12'h1;
            if (nBits == 12) mask = 12'hFFF;
            check((gotV & mask) == (expV & mask), curTag, {20'd0, gotV & mask}, {20'd0, expV & mask});
            inFrame = 1'b0;
            if (txLine == 1'b0) startFrame(1'b1);
          end
        end
      end else if (txLine == 1'b0) begin
        startFrame(1'b0);
      end
    end
    refTick = (refMode == 0) ? 1'b1 : 1'($urandom % 2);
  end

  task automatic sendByte(input logic [7:0] d, input string tag, input bit track);
    @(negedge clk);
    inValid = 1'b1;
    inData = d;
    while (!inReady) @(negedge clk);
    if (track) begin
      qData[qTail % 256] = d;
      qCfg[qTail % 256]  = lineCtrl;
      qDiv[qTail % 256]  = divisor;
      qTag[qTail % 256]  = tag;
      qTail++;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!(shiftEmpty && holdEmpty && !inFrame && !inValid));
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2 watchdog expired", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    bit ok;
    int nb;
    void'($urandom(32'h1F2E3D));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1, "R1 reset line high", txLine, 1);
    check(holdEmpty == 1'b1, "R1 reset holdEmpty", holdEmpty, 1);
    check(shiftEmpty == 1'b1, "R1 reset shiftEmpty", shiftEmpty, 1);
    check(inReady == 1'b1, "R1 reset inReady", inReady, 1);

    // R3 every word length
    divisor = 16'd1;
    for (int ws = 0; ws < 4; ws++) begin
      lineCtrl = mkCfg(0, 0, 0, 0, 0, 2'(ws));
      sendByte(8'hB6 ^ 8'(ws * 37), "R3 word length", 1'b1);
      waitIdle();
    end

    // R5 even and odd parity on several patterns
    for (int ev = 0; ev < 2; ev++) begin
      for (int k = 0; k < 4; k++) begin
        lineCtrl = mkCfg(0, 0, 1'(ev), 1, 0, (k % 2 == 0) ? 2'd3 : 2'd1);
        sendByte((k == 0) ? 8'h00 : (k == 1) ? 8'h21 : (k == 2) ? 8'hFF : 8'h96, "R5 parity", 1'b1);
        waitIdle();
      end
    end

    // R6 constant parity, and constant select without parity enable
    lineCtrl = mkCfg(0, 1, 1, 1, 0, 2'd3);
    sendByte(8'h01, "R6 constant parity even-select", 1'b1);
    waitIdle();
    lineCtrl = mkCfg(0, 1, 0, 1, 1, 2'd2);
    sendByte(8'h03, "R6 constant parity odd-select", 1'b1);
    waitIdle();
    lineCtrl = mkCfg(0, 1, 0, 0, 0, 2'd3);
    sendByte(8'h7E, "R6 constant select without enable", 1'b1);
    waitIdle();

    // R4 and R9: two stop bits back to back
    base = framesStarted;
    lineCtrl = mkCfg(0, 0, 0, 0, 1, 2'd3);
    sendByte(8'h5A, "R4 two stop bits", 1'b1);
    sendByte(8'hC3, "R4 two stop bits", 1'b1);
    check(holdEmpty == 1'b0, "R10 hold full while frame runs", holdEmpty, 0);
    check(inReady == 1'b0, "R9 not ready while hold full", inReady, 0);
    check(shiftEmpty == 1'b0, "R10 shifter busy during frame", shiftEmpty, 0);
    waitIdle();
    check(gapLog[(base + 1) % 256] == 1'b1, "R9 no gap with two stops", gapLog[(base + 1) % 256], 1);
    check(shiftEmpty && holdEmpty, "R10 both empty after drain", {shiftEmpty, holdEmpty}, 2'b11);

    base = framesStarted;
    lineCtrl = mkCfg(0, 0, 1, 1, 0, 2'd0);
    sendByte(8'h15, "R4 one stop bit", 1'b1);
    sendByte(8'h0A, "R4 one stop bit", 1'b1);
    waitIdle();
    check(gapLog[(base + 1) % 256] == 1'b1, "R9 no gap with one stop", gapLog[(base + 1) % 256], 1);

    // R11 setup change during a frame
    lineCtrl = mkCfg(0, 0, 1, 1, 0, 2'd2);
    divisor = 16'd1;
    sendByte(8'h3C, "R11 setup held for running frame", 1'b1);
    do @(negedge clk); while (shiftEmpty);
    repeat (20) @(negedge clk);
    lineCtrl = mkCfg(0, 0, 0, 0, 1, 2'd0);
    divisor = 16'd2;
    waitIdle();
    sendByte(8'hE7, "R11 new setup on next frame", 1'b1);
    waitIdle();

    // R8 divisor 3 with thinned reference ticks
    refMode = 1;
    divisor = 16'd3;
    lineCtrl = mkCfg(0, 0, 1, 1, 1, 2'd3);
    sendByte(8'h9D, "R8 bit length 16x divisor", 1'b1);
    sendByte(8'h42, "R8 bit length 16x divisor", 1'b1);
    waitIdle();
    refMode = 0;

    // R2 random setups and data
    for (int g = 0; g < 20; g++) begin
      lineCtrl = 7'($urandom) & 7'h3F;
      divisor = 16'(1 + $urandom % 3);
      refMode = int'($urandom % 2);
      nb = 1 + int'($urandom % 3);
      for (int k = 0; k < nb; k++) sendByte(8'($urandom), "R2 random frame", 1'b1);
      waitIdle();
    end
    refMode = 0;

    // R7 break while idle
    monEn = 1'b0;
    divisor = 16'd1;
    lineCtrl = mkCfg(1, 0, 0, 0, 0, 2'd3);
    @(negedge clk);
    check(txLine == 1'b0, "R7 break drives line low", txLine, 0);
    ok = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (txLine) ok = 1'b0;
    end
    check(ok, "R7 break held continuously", ok, 1);
    lineCtrl = mkCfg(0, 0, 0, 0, 0, 2'd3);
    @(negedge clk);
    check(txLine == 1'b1, "R7 line released after break", txLine, 1);

    // R7 break during a frame
    sendByte(8'hFF, "R7", 1'b0);
    do @(negedge clk); while (shiftEmpty);
    repeat (30) @(negedge clk);
    lineCtrl = mkCfg(1, 0, 0, 0, 0, 2'd3);
    ok = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (txLine) ok = 1'b0;
    end
    check(ok, "R7 break overrides frame", ok, 1);
    lineCtrl = mkCfg(0, 0, 0, 0, 0, 2'd3);
    waitIdle();
    check(txLine == 1'b1, "R7 idle high after break frame", txLine, 1);

    // R8 divisor zero counts as 65536
    divisor = 16'd0;
    sendByte(8'h00, "R8", 1'b0);
    do @(negedge clk); while (shiftEmpty);
    repeat (20000) @(negedge clk);
    check(txLine == 1'b0, "R8 divisor zero keeps start bit", txLine, 0);
    check(shiftEmpty == 1'b0, "R8 divisor zero frame still busy", shiftEmpty, 0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    divisor = 16'd1;
    @(negedge clk);
    check(txLine && shiftEmpty && holdEmpty, "R1 state after second reset",
          {txLine, shiftEmpty, holdEmpty}, 3'b111);
    monEn = 1'b1;

    lineCtrl = mkCfg(0, 0, 0, 1, 1, 2'd1);
    sendByte(8'h2D, "R2 frame after reset", 1'b1);
    waitIdle();

    check(qHead == qTail, "R9 every accepted byte was sent", qHead, qTail);
    summary();
    done = 1'b1;
    $finish;
  end

endmodule